// File: doc/BRIEF.md
# Slow Clock Period Calibration Counter

This block measures how long a chosen low-frequency clock really runs, expressed in cycles of a fast reference clock. Software selects one of three slow sources: the 32 kHz crystal path, the internal fast oscillator divided by 256, or whatever the slow-clock mux is currently delivering. It programs how many slow cycles to span and raises a start bit. It then polls a ready flag and reads the count. The count is the number of reference cycles that elapsed over that many slow periods. Firmware uses it to derive the true slow-clock period.

The block owns the software-programmed enable bits of the crystal path and of the divide-by-256 path. At launch it captures both bits and switches on the requested path if that path is off. When the run ends it writes the captured bits back unchanged. Before counting, it predicts the run length from the nominal frequency of the source. If that prediction does not fit the result register, the run is refused. If no result arrives within twice the prediction, the run is abandoned. A count that saturates is also treated as an error. Every error reports a result of 0. The oscillators themselves are outside the block and arrive as plain clock inputs, sampled in the reference domain.

Top module: `slowcal_meter`

## Requirements
- R1: With a slow period of P reference cycles and a programmed span of N slow cycles, a successful run reports `result` = N*P, with `err` low, and the slow clock is sampled through a two-flop synchroniser whose rising edges are counted.
- R2: `src_sel` encoding: 0 = crystal path (`xtal_clk`), 1 = divided oscillator (`div_clk`), 2 or 3 = mux output (`mux_clk`). The nominal reference-cycles-per-slow-cycle ratio used for prediction is REF_HZ/XTAL_HZ for the crystal and REF_HZ*256/FOSC_HZ for the divided source. For the mux output the ratio follows `mux_sel`: 0 or 3 = RC oscillator (REF_HZ/RC_HZ), 1 = crystal ratio, 2 = divided ratio.
- R3: A run launches only on a low-to-high change of `start` seen at a clock edge. Holding `start` high never relaunches, and a rising `start` while `busy` is high is ignored.
- R4: `busy` rises on the edge after a launch and falls when the run ends; `ready` is cleared at launch and set when the run ends; `busy` and `ready` are never high together.
- R5: While a run is busy, `osc_xtal_en`/`osc_div_en` equal the values captured at launch, with the requested path's bit forced high (source 0 sets the crystal bit, source 1 the divided bit, the mux source sets neither). At the end of the run both outputs return exactly to the captured values. Enable writes (`en_we`) are applied on the next edge when idle and ignored while busy.
- R6: If N*ratio >= 2^RES_W, or N = 0, the launch is refused: on the next edge `ready` and `err` are high, `result` is 0, `busy` stays low and the enables do not change.
- R7: If the span has not completed TL = 2*N*ratio reference cycles after launch, the run is abandoned with `err` high and `result` 0.
- R8: The measured count saturates at 2^RES_W-1 instead of wrapping, and a saturated count ends the run with `err` high and `result` 0.
- R9: After reset `busy`, `ready`, `err`, `result` and both enable outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run request; its rising edge launches |
| src_sel | input | 2 | Slow source to measure |
| cal_cycles | input | CYC_W | Number of slow cycles to span |
| mux_sel | input | 2 | Source currently feeding the slow-clock mux |
| en_we | input | 1 | Write strobe for the enable bits |
| en_xtal_wr | input | 1 | Crystal path enable value to write |
| en_div_wr | input | 1 | Divided oscillator enable value to write |
| xtal_clk | input | 1 | Crystal path slow clock |
| div_clk | input | 1 | Divided oscillator slow clock |
| mux_clk | input | 1 | Slow-clock mux output |
| osc_xtal_en | output | 1 | Crystal path enable |
| osc_div_en | output | 1 | Divided oscillator enable |
| busy | output | 1 | Run in progress |
| ready | output | 1 | Last run finished |
| err | output | 1 | Last run refused, timed out or saturated |
| result | output | RES_W | Reference cycles over the span, 0 on error |

## Verification
The bench drives each of the three sources with distinct slow periods (10, 8 and 6 reference cycles) and two different spans. A result equal to N*P shows that the right clock was routed and counted, not merely that some clock was. The same crystal source is then slowed to 12 cycles, so a count taken from the nominal ratio instead of the measured edges would be caught. A dead crystal, an oversized span, a zero span, a mux whose nominal ratio flips the overflow decision, and a slow clock that drives the count into saturation each separate one error path from the others. Enable writes and extra start edges issued mid-run show whether the captured state and the run survive them.

// File: rtl/slowcal_pkg.sv
// Shared types for the slow clock calibration counter.
package slowcal_pkg;
    // Slow source requested for a run (2-bit field, 3 behaves as MUX).
    typedef enum logic [1:0] {
        SRC_XTAL = 2'd0,
        SRC_DIV  = 2'd1,
        SRC_MUX  = 2'd2,
        SRC_MUX2 = 2'd3
    } src_e;

    // Source currently feeding the slow-clock mux (3 behaves as RC).
    typedef enum logic [1:0] {
        MUX_RC   = 2'd0,
        MUX_XTAL = 2'd1,
        MUX_DIV  = 2'd2,
        MUX_RC2  = 2'd3
    } mux_e;

    // Counting engine phases.
    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_ARM  = 2'd1,
        CNT_RUN  = 2'd2
    } cnt_state_e;

    localparam int RATIO_W = 32;
endpackage

// File: rtl/slowcal_sync.sv
// Brings a slow clock into the reference domain and flags its rising edges.
// Assumes the slow clock period is several reference cycles long.
module slowcal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Synchroniser chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], slow_in};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;

    // A rising edge is one cycle wide and cannot repeat on the next cycle (R1).
    assert_edge_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/slowcal_estimator.sv
// Predicts the run length from the nominal source frequency and decides
// whether the run fits the result register. Purely combinational.
module slowcal_estimator
    import slowcal_pkg::*;
#(
    parameter int CYC_W   = 15,
    parameter int RES_W   = 24,
    parameter int REF_HZ  = 40_000_000,
    parameter int XTAL_HZ = 32_768,
    parameter int FOSC_HZ = 8_500_000,
    parameter int RC_HZ   = 150_000,
    localparam int EW     = CYC_W + RATIO_W,
    localparam int TW     = EW + 1
) (
    input  logic [1:0]       src,
    input  logic [1:0]       mux_src,
    input  logic [CYC_W-1:0] cycles,
    output logic             refuse,
    output logic [TW-1:0]    tlim
);
    localparam logic [63:0] R_XTAL = 64'(REF_HZ) / 64'(XTAL_HZ);
    localparam logic [63:0] R_DIV  = (64'(REF_HZ) * 64'd256) / 64'(FOSC_HZ);
    localparam logic [63:0] R_RC   = 64'(REF_HZ) / 64'(RC_HZ);

    logic [RATIO_W-1:0] ratio;
    logic [EW-1:0]      expected;

    // Pick the nominal ratio of the requested source.
    always_comb begin
        unique case (src)
            SRC_XTAL: ratio = R_XTAL[RATIO_W-1:0];
            SRC_DIV:  ratio = R_DIV[RATIO_W-1:0];
            default: begin
                unique case (mux_src)
                    MUX_XTAL: ratio = R_XTAL[RATIO_W-1:0];
                    MUX_DIV:  ratio = R_DIV[RATIO_W-1:0];
                    default:  ratio = R_RC[RATIO_W-1:0];
                endcase
            end
        endcase
    end

    // Predicted count, refusal decision and timeout limit.
    always_comb begin
        expected = EW'(cycles) * EW'(ratio);
        refuse   = (cycles == '0) || ((expected >> RES_W) != '0);
        tlim     = {expected, 1'b0};
    end
endmodule

// File: rtl/slowcal_counter.sv
// Counting engine: after launch waits for a first slow edge, then counts
// reference cycles until the programmed number of slow edges has passed.
// Abandons the run when the timeout limit is reached. Assumes launch only
// arrives while idle.
module slowcal_counter
    import slowcal_pkg::*;
#(
    parameter int CYC_W    = 15,
    parameter int RES_W    = 24,
    parameter int TW       = 48,
    parameter int ARM_HOLD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [CYC_W-1:0] target,
    input  logic [TW-1:0]    tlim,
    input  logic             edge_pulse,
    output logic             done,
    output logic             fail,
    output logic [RES_W-1:0] value
);
    localparam logic [RES_W-1:0] CMAX = '1;

    cnt_state_e       state;
    logic [RES_W-1:0] cnt;
    logic [RES_W-1:0] nxt;
    logic [CYC_W-1:0] edges;
    logic [CYC_W-1:0] target_q;
    logic [TW-1:0]    tlim_q;
    logic [TW-1:0]    tcnt;
    logic             last_edge;

    // Saturating next count and span completion test.
    always_comb begin
        nxt       = (cnt == CMAX) ? CMAX : cnt + 1'b1;
        last_edge = edge_pulse && (({1'b0, edges} + 1'b1) == {1'b0, target_q});
    end

    // Run sequencing: arm, count, finish or abandon.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CNT_IDLE;
            cnt      <= '0;
            edges    <= '0;
            target_q <= '0;
            tlim_q   <= '0;
            tcnt     <= '0;
            done     <= 1'b0;
            fail     <= 1'b0;
            value    <= '0;
        end else begin
            done <= 1'b0;
            if (state == CNT_IDLE) begin
                if (launch) begin
                    state    <= CNT_ARM;
                    tcnt     <= '0;
                    target_q <= target;
                    tlim_q   <= tlim;
                end
            end else begin
                tcnt <= tcnt + 1'b1;
                if (state == CNT_RUN && last_edge) begin
                    state <= CNT_IDLE;
                    done  <= 1'b1;
                    fail  <= (nxt == CMAX);
                    value <= nxt;
                end else if ((tcnt + 1'b1) >= tlim_q) begin
                    state <= CNT_IDLE;
                    done  <= 1'b1;
                    fail  <= 1'b1;
                    value <= '0;
                end else if (state == CNT_ARM) begin
                    if (edge_pulse && tcnt >= TW'(ARM_HOLD)) begin
                        state <= CNT_RUN;
                        cnt   <= '0;
                        edges <= '0;
                    end
                end else begin
                    cnt <= nxt;
                    if (edge_pulse) edges <= edges + 1'b1;
                end
            end
        end
    end

    // Count holds at its ceiling while running instead of wrapping (R8).
    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CNT_RUN && cnt == CMAX) |=> (cnt == CMAX || state == CNT_IDLE));

    // An active run never outlives its timeout limit (R7).
    assert_timeout_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CNT_IDLE) |-> (tcnt < tlim_q));
endmodule

// File: rtl/slowcal_meter.sv
// Slow clock period calibration counter, top level. Holds the oscillator
// enable bits, launches runs on a start edge, forces the requested source on
// for the run and restores the captured enables afterwards. Assumes start and
// the configuration inputs are synchronous to clk.
module slowcal_meter
    import slowcal_pkg::*;
#(
    parameter int CYC_W   = 15,
    parameter int RES_W   = 24,
    parameter int REF_HZ  = 40_000_000,
    parameter int XTAL_HZ = 32_768,
    parameter int FOSC_HZ = 8_500_000,
    parameter int RC_HZ   = 150_000,
    parameter int SYNC_N  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       src_sel,
    input  logic [CYC_W-1:0] cal_cycles,
    input  logic [1:0]       mux_sel,
    input  logic             en_we,
    input  logic             en_xtal_wr,
    input  logic             en_div_wr,
    input  logic             xtal_clk,
    input  logic             div_clk,
    input  logic             mux_clk,
    output logic             osc_xtal_en,
    output logic             osc_div_en,
    output logic             busy,
    output logic             ready,
    output logic             err,
    output logic [RES_W-1:0] result
);
    localparam int TW = CYC_W + RATIO_W + 1;

    logic          start_q;
    logic          launch;
    logic          refuse;
    logic [TW-1:0] tlim;
    logic [1:0]    src_q;
    logic          slow_sel;
    logic          rise;
    logic          cnt_done;
    logic          cnt_fail;
    logic [RES_W-1:0] cnt_value;
    logic          cap_x;
    logic          cap_d;

    assign launch = start & ~start_q & ~busy;

    // Route the slow clock of the latched source to the synchroniser.
    always_comb begin
        unique case (src_q)
            SRC_XTAL: slow_sel = xtal_clk;
            SRC_DIV:  slow_sel = div_clk;
            default:  slow_sel = mux_clk;
        endcase
    end

    slowcal_estimator #(
        .CYC_W(CYC_W), .RES_W(RES_W), .REF_HZ(REF_HZ),
        .XTAL_HZ(XTAL_HZ), .FOSC_HZ(FOSC_HZ), .RC_HZ(RC_HZ)
    ) i_est (
        .src(src_sel), .mux_src(mux_sel), .cycles(cal_cycles),
        .refuse(refuse), .tlim(tlim)
    );

    slowcal_sync #(.STAGES(SYNC_N)) i_sync (
        .clk(clk), .rst_n(rst_n), .slow_in(slow_sel), .rise(rise)
    );

    slowcal_counter #(.CYC_W(CYC_W), .RES_W(RES_W), .TW(TW)) i_cnt (
        .clk(clk), .rst_n(rst_n), .launch(launch && !refuse),
        .target(cal_cycles), .tlim(tlim), .edge_pulse(rise),
        .done(cnt_done), .fail(cnt_fail), .value(cnt_value)
    );

    // Start history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start;
    end

    // Run control, status, result and enable ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            ready       <= 1'b0;
            err         <= 1'b0;
            result      <= '0;
            src_q       <= SRC_XTAL;
            cap_x       <= 1'b0;
            cap_d       <= 1'b0;
            osc_xtal_en <= 1'b0;
            osc_div_en  <= 1'b0;
        end else if (busy) begin
            if (cnt_done) begin
                busy        <= 1'b0;
                ready       <= 1'b1;
                err         <= cnt_fail;
                result      <= cnt_fail ? '0 : cnt_value;
                osc_xtal_en <= cap_x;
                osc_div_en  <= cap_d;
            end
        end else if (launch) begin
            if (refuse) begin
                ready  <= 1'b1;
                err    <= 1'b1;
                result <= '0;
            end else begin
                busy        <= 1'b1;
                ready       <= 1'b0;
                err         <= 1'b0;
                src_q       <= src_sel;
                cap_x       <= osc_xtal_en;
                cap_d       <= osc_div_en;
                osc_xtal_en <= osc_xtal_en | (src_sel == SRC_XTAL);
                osc_div_en  <= osc_div_en  | (src_sel == SRC_DIV);
            end
        end else if (en_we) begin
            osc_xtal_en <= en_xtal_wr;
            osc_div_en  <= en_div_wr;
        end
    end

    // Busy and ready are mutually exclusive (R4).
    assert_busy_ready_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ready));

    // An error always reports a zero result (R7, R8).
    assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (result == '0));

    // Enables return to the captured values when a run ends (R5).
    assert_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (osc_xtal_en == cap_x && osc_div_en == cap_d));

    // A refused launch finishes at once with an error and no run (R6).
    assert_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && refuse) |=> (ready && err && !busy));
endmodule

// File: tb/test_slowcal_meter.sv
// Self-checking bench for slowcal_meter with a behavioural per-clock model.
module test_slowcal_meter;
    localparam int CLK_PERIOD = 10;
    localparam int CYC_W = 15;
    localparam int RES_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [CYC_W-1:0] cal_cycles = '0;
    logic [1:0] mux_sel = 2'd0;
    logic en_we = 1'b0, en_xtal_wr = 1'b0, en_div_wr = 1'b0;
    logic xtal_clk = 1'b0, div_clk = 1'b0, mux_clk = 1'b0;
    logic osc_xtal_en, osc_div_en, busy, ready, err;
    logic [RES_W-1:0] result;

    int checks = 0;
    int errors = 0;
    int xtal_half = 5;
    bit xtal_dead = 1'b0;
    int xc = 0, dc = 0, mc = 0;

    // Behavioural model state.
    bit m_busy = 1'b0;
    bit sw_x = 1'b0, sw_d = 1'b0;
    bit ex_x = 1'b0, ex_d = 1'b0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slowcal_meter #(
        .CYC_W(CYC_W), .RES_W(RES_W), .REF_HZ(327680), .XTAL_HZ(32768),
        .FOSC_HZ(10485760), .RC_HZ(54613)
    ) i_slowcal_meter (
        .clk(clk), .rst_n(rst_n), .start(start), .src_sel(src_sel),
        .cal_cycles(cal_cycles), .mux_sel(mux_sel), .en_we(en_we),
        .en_xtal_wr(en_xtal_wr), .en_div_wr(en_div_wr), .xtal_clk(xtal_clk),
        .div_clk(div_clk), .mux_clk(mux_clk), .osc_xtal_en(osc_xtal_en),
        .osc_div_en(osc_div_en), .busy(busy), .ready(ready), .err(err),
        .result(result)
    );

    // Oscillator models: gated sources stop while their enable is low.
    always @(negedge clk) begin
        if (!osc_xtal_en || xtal_dead) begin xtal_clk <= 1'b0; xc <= 0; end
        else if (xc == xtal_half - 1) begin xtal_clk <= ~xtal_clk; xc <= 0; end
        else xc <= xc + 1;
        if (!osc_div_en) begin div_clk <= 1'b0; dc <= 0; end
        else if (dc == 3) begin div_clk <= ~div_clk; dc <= 0; end
        else dc <= dc + 1;
        if (mc == 2) begin mux_clk <= ~mux_clk; mc <= 0; end
        else mc <= mc + 1;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison of busy and enables against the model (R4, R5).
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (mon_on) begin
            if (ready && m_busy) m_busy = 1'b0;
            check(busy == m_busy, "R4 busy", busy, m_busy);
            check(!(busy && ready), "R4 busy/ready exclusive", ready, 0);
            check(osc_xtal_en == (m_busy ? ex_x : sw_x), "R5 xtal enable",
                  osc_xtal_en, m_busy ? ex_x : sw_x);
            check(osc_div_en == (m_busy ? ex_d : sw_d), "R5 div enable",
                  osc_div_en, m_busy ? ex_d : sw_d);
        end
    end

    task automatic sw_write(input bit x, input bit d);
        @(negedge clk);
        en_we = 1'b1; en_xtal_wr = x; en_div_wr = d;
        if (!m_busy) begin sw_x = x; sw_d = d; end
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic launch(input logic [1:0] s, input int n, input bit accepted);
        @(negedge clk);
        start = 1'b0; src_sel = s; cal_cycles = CYC_W'(n);
        @(negedge clk);
        start = 1'b1;
        if (accepted) begin
            m_busy = 1'b1;
            ex_x = sw_x | (s == 2'd0);
            ex_d = sw_d | (s == 2'd1);
        end
    endtask

    task automatic wait_ready(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!ready && cyc < 5000);
    endtask

    task automatic run_ok(input logic [1:0] s, input int n, input int p, input string tag);
        int cyc;
        launch(s, n, 1'b1);
        wait_ready(cyc);
        check(ready && !err && result == RES_W'(n * p), tag, result, n * p);
    endtask

    task automatic run_refused(input logic [1:0] s, input int n, input string tag);
        launch(s, n, 1'b0);
        @(posedge clk); #(CLK_PERIOD/4);
        check(ready && err && result == 0 && !busy, tag, {ready, err, busy}, 3'b110);
    endtask

    initial begin
        int cyc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state.
        check({busy, ready, err, osc_xtal_en, osc_div_en} == 5'b0 && result == 0,
              "R9 reset state", {busy, ready, err, osc_xtal_en, osc_div_en}, 0);
        mon_on = 1'b1;

        // R1 R2: crystal, period 10, span 20.
        run_ok(2'd0, 20, 10, "R1 R2 crystal 20x10");
        // R2 R5: divided source with crystal enabled by software.
        sw_write(1'b1, 1'b0);
        run_ok(2'd1, 16, 8, "R2 R5 divided 16x8");
        // R2: mux output, RC ratio, period 6.
        mux_sel = 2'd0;
        run_ok(2'd2, 30, 6, "R2 mux rc 30x6");
        run_ok(2'd3, 110, 6, "R2 mux code3 110x6");
        // R2 R6: same span with mux declaring crystal predicts 1100, refused.
        mux_sel = 2'd1;
        run_refused(2'd2, 110, "R2 R6 mux crystal ratio refusal");
        mux_sel = 2'd0;
        // R1: measured period differs from nominal.
        xtal_half = 6;
        run_ok(2'd0, 20, 12, "R1 slow crystal 20x12");
        xtal_half = 5;

        // R3 R5: writes and start edges during a run are ignored.
        launch(2'd0, 40, 1'b1);
        repeat (30) @(negedge clk);
        sw_write(1'b0, 1'b1);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1;
        wait_ready(cyc);
        check(!err && result == RES_W'(400), "R3 restart ignored mid-run", result, 400);
        check(osc_xtal_en == 1'b1 && osc_div_en == 1'b0, "R5 write while busy ignored",
              {osc_xtal_en, osc_div_en}, 2'b10);

        // R3: start held high does not relaunch.
        repeat (40) @(negedge clk);
        check(!busy && ready, "R3 held start no relaunch", busy, 0);

        // R6: oversized and zero spans.
        run_refused(2'd0, 200, "R6 overflow refusal");
        run_refused(2'd0, 0, "R6 zero span refusal");
        check(osc_xtal_en == 1'b1 && osc_div_en == 1'b0, "R6 enables untouched",
              {osc_xtal_en, osc_div_en}, 2'b10);

        // R7: dead crystal times out after 2*20*10 cycles.
        sw_write(1'b0, 1'b0);
        xtal_dead = 1'b1;
        launch(2'd0, 20, 1'b1);
        wait_ready(cyc);
        check(err && result == 0, "R7 timeout error", result, 0);
        check(cyc >= 398 && cyc <= 404, "R7 timeout length", cyc, 402);
        xtal_dead = 1'b0;

        // R8: 90 slow cycles of 12 gives 1080, above 1023: saturates.
        xtal_half = 6;
        launch(2'd0, 90, 1'b1);
        wait_ready(cyc);
        check(err && result == 0, "R8 saturation error", result, 0);
        xtal_half = 5;

        // R1: span of one cycle.
        run_ok(2'd0, 1, 10, "R1 single cycle span");

        start = 1'b0;
        repeat (5) @(negedge clk);
        mon_on = 1'b0;
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule